// File: doc/BRIEF.md
# Zero-turnaround synchronous SRAM core

This block is a synthesizable single-port synchronous SRAM. Reads and writes can follow each other in any order on consecutive clocks, and no idle cycle is needed at a bus direction change. A static mode strap picks one of two timings. In pipelined timing the read word passes through an output register and write data trails its address by two clocks. In flow-through timing the read word comes straight from the array and write data trails its address by one clock. Between its address and its data, a write waits in a short queue. A pipelined read that hits that queue takes the bytes still on their way from the data bus instead of the stale array word.

Each selected cycle carries one word. A burst continues from a start address by pulsing the advance input, and a strap picks the beat order: linear or interleaved over the two low address bits. Three chip selects allow depth expansion. An output enable and a sleep input act on the data drivers at once, without waiting for a clock. The shared data bus is split into an input, an output and a drive enable.

There is no valid/ready handshake. The bus timing is fixed by the mode strap and the block has no back-pressure: every selected cycle is accepted on its clock edge, and the bus master must present write data exactly on the beat that the mode dictates.

Top module: `zt_sram`

## Requirements
- R1: Control, address and byte enables are sampled only at the rising clock edge. A cycle is a new access when `sel0_i`, `sel1_i` and `sel2_i` are all 1, `adv_i` is 0 and `sleep_i` is 0. `wr_i`=1 makes it a write and `wr_i`=0 makes it a read.
- R2: With `pipe_mode_i`=1, a read sampled at edge k drives its word on `dq_o` with `dq_oe_o`=1 during the clock period that follows edge k+1.
- R3: With `pipe_mode_i`=0, a read sampled at edge k drives its word during the clock period that follows edge k.
- R4: A write sampled at edge k takes its data from `dq_i` at edge k+2 when `pipe_mode_i`=1, and at edge k+1 when `pipe_mode_i`=0.
- R5: Byte lane i is bits [9i+8:9i]. It is written only when `byte_en_i[i]`=1 in the write's address cycle. Lanes that are not enabled keep their previous contents.
- R6: Reads and writes may alternate on every clock in either order. `dq_oe_o` is never 1 during a clock period whose closing edge takes write data.
- R7: With `adv_i`=1 after an active cycle, the previous access type continues to the next beat, and address, `wr_i` and the chip selects are ignored. Beat n (0 to 3, wrapping) keeps the upper address bits and sets the low two bits to start+n mod 4 when `burst_ilv_i`=0, or to start XOR n when `burst_ilv_i`=1. An `adv_i`=1 that follows an idle cycle is itself idle.
- R8: In pipelined mode, a read of an address whose write data has not yet been taken returns that pending data in the enabled lanes and array data in the others.
- R9: `oe_i`=0 forces `dq_oe_o` to 0 at once. The value on `dq_o` is unaffected.
- R10: While `sleep_i`=1, `dq_oe_o` is 0, no access is accepted and any burst ends. Writes accepted earlier still take their data, and array contents are kept.
- R11: After reset `dq_oe_o` is 0, no burst is live and no write is pending. Array contents survive reset.
- R12: A cycle in which any chip select is 0 and `adv_i` is 0 is idle. It produces no output and ends any burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_mode_i | input | 1 | Static strap: 1 pipelined, 0 flow-through |
| burst_ilv_i | input | 1 | Static strap: 1 interleaved beat order, 0 linear |
| sel0_i | input | 1 | Chip select 0, active high |
| sel1_i | input | 1 | Chip select 1, active high |
| sel2_i | input | 1 | Chip select 2, active high |
| adv_i | input | 1 | Continue the live burst to its next beat |
| wr_i | input | 1 | 1 write, 0 read, for a new access |
| byte_en_i | input | LANES | Per-lane write enable, sampled with the address |
| addr_i | input | ADDR_W | Word address of a new access |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Power-down: blocks accesses and drivers |
| dq_i | input | LANES*BYTE_W | Data bus, inbound side |
| dq_o | output | LANES*BYTE_W | Data bus, outbound side |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
An address or lane enable that is wrong in the late-write queue stores data in the wrong place. Nothing shows until that word is read back, which is then at most one or two clocks later through forwarding or at any later read. A burst counter or beat order that is off puts a wrong word on `dq_o` on the very next beat, and the comparison against a behavioural model on every clock catches it there. A drive-enable flag that is off by one stage shows as `dq_oe_o` high one period early or late, so the mode latencies and bus turnaround are exposed in the period where they go wrong.

// File: rtl/zt_pkg.sv
package zt_pkg;

  // Access carried by one sampled cycle.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low address bits of a burst beat: linear add or interleaved xor.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              adv_i,
  input  logic              sel_all_i,
  input  logic              wr_i,
  input  logic              ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic              live_q;
  logic              kind_wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic              cont;
  logic              start;
  logic [1:0]        beat_nx;

  // Decode of the cycle presented at the coming edge.
  always_comb begin
    cont    = !sleep_i && adv_i && live_q;
    start   = !sleep_i && !adv_i && sel_all_i;
    beat_nx = beat_q + 2'd1;
    op_o    = OP_IDLE;
    addr_o  = addr_i;
    if (cont) begin
      op_o   = kind_wr_q ? OP_WRITE : OP_READ;
      addr_o = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], beat_nx, ilv_i)};
    end else if (start) begin
      op_o = wr_i ? OP_WRITE : OP_READ;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q    <= 1'b0;
      kind_wr_q <= 1'b0;
      base_q    <= '0;
      beat_q    <= '0;
    end else begin
      live_q <= cont | start;
      if (start) begin
        base_q    <= addr_i;
        kind_wr_q <= wr_i;
        beat_q    <= '0;
      end else if (cont) begin
        beat_q <= beat_nx;
      end
    end
  end

  AST_LIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cont && !ilv_i) |-> (addr_o[1:0] == $past(addr_o[1:0]) + 2'd1)); // R7
  AST_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont |-> (addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]))); // R7

endmodule

// File: rtl/zt_write_queue.sv
module zt_write_queue #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pipe_i,
  input  logic              in_wr_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [LANES-1:0]  in_be_i,
  output logic              cm_en_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [LANES-1:0]  cm_be_o
);

  // Extra stage used only by the double-late timing.
  logic              s2_v;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_be;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v    <= 1'b0;
      s2_addr <= '0;
      s2_be   <= '0;
    end else begin
      s2_v    <= pipe_i & in_wr_i;
      s2_addr <= in_addr_i;
      s2_be   <= in_be_i;
    end
  end

  // Entry whose data is on the bus in this period.
  always_comb begin
    if (pipe_i) begin
      cm_en_o   = s2_v;
      cm_addr_o = s2_addr;
      cm_be_o   = s2_be;
    end else begin
      cm_en_o   = in_wr_i;
      cm_addr_o = in_addr_i;
      cm_be_o   = in_be_i;
    end
  end

  AST_DBL_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_i && cm_en_o) |-> $past(in_wr_i)); // R4

endmodule

// File: rtl/zt_mem_array.sv
module zt_mem_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                      clk_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         waddr_i,
  input  logic [LANES-1:0]          wbe_i,
  input  logic [LANES*BYTE_W-1:0]   wdata_i,
  input  logic [ADDR_W-1:0]         raddr_i,
  output logic [LANES*BYTE_W-1:0]   rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wbe_i[l]) begin
        cells[waddr_i] <= wdata_i[l*BYTE_W +: BYTE_W];
      end
    end

    assign rdata_o[l*BYTE_W +: BYTE_W] = cells[raddr_i];
  end

endmodule

// File: rtl/zt_read_port.sv
module zt_read_port #(
  parameter int LANES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pipe_i,
  input  logic                    oe_i,
  input  logic                    sleep_i,
  input  logic                    rd_now_i,
  input  logic [LANES*BYTE_W-1:0] arr_i,
  input  logic                    fwd_hit_i,
  input  logic [LANES-1:0]        fwd_be_i,
  input  logic [LANES*BYTE_W-1:0] wdata_i,
  output logic [LANES*BYTE_W-1:0] dq_o,
  output logic                    dq_oe_o
);

  localparam int DATA_W = LANES * BYTE_W;

  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rq_d;
  logic              rq_v;

  // Pending write bytes replace stale array bytes lane by lane.
  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*BYTE_W +: BYTE_W] = (fwd_hit_i && fwd_be_i[l]) ?
      wdata_i[l*BYTE_W +: BYTE_W] : arr_i[l*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_v <= 1'b0;
      rq_d <= '0;
    end else begin
      rq_v <= pipe_i & rd_now_i;
      if (rd_now_i) begin
        rq_d <= merged;
      end
    end
  end

  assign dq_o    = pipe_i ? rq_d : arr_i;
  assign dq_oe_o = oe_i && !sleep_i && (pipe_i ? rq_v : rd_now_i);

  AST_PIPE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_i && dq_oe_o) |-> $past(rd_now_i)); // R2

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pipe_mode_i,
  input  logic                    burst_ilv_i,
  input  logic                    sel0_i,
  input  logic                    sel1_i,
  input  logic                    sel2_i,
  input  logic                    adv_i,
  input  logic                    wr_i,
  input  logic [LANES-1:0]        byte_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    oe_i,
  input  logic                    sleep_i,
  input  logic [LANES*BYTE_W-1:0] dq_i,
  output logic [LANES*BYTE_W-1:0] dq_o,
  output logic                    dq_oe_o
);

  localparam int DATA_W = LANES * BYTE_W;

  op_e               nxt_op;
  logic [ADDR_W-1:0] nxt_addr;
  op_e               cyc_op_q;
  logic [ADDR_W-1:0] cyc_addr_q;
  logic [LANES-1:0]  cyc_be_q;
  logic              cm_en;
  logic [ADDR_W-1:0] cm_addr;
  logic [LANES-1:0]  cm_be;
  logic [DATA_W-1:0] arr_rd;
  logic              rd_now;
  logic              fwd_hit;

  zt_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sleep_i   (sleep_i),
    .adv_i     (adv_i),
    .sel_all_i (sel0_i & sel1_i & sel2_i),
    .wr_i      (wr_i),
    .ilv_i     (burst_ilv_i),
    .addr_i    (addr_i),
    .op_o      (nxt_op),
    .addr_o    (nxt_addr)
  );

  // Sampled access: the first late-write stage and the read address.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_op_q   <= OP_IDLE;
      cyc_addr_q <= '0;
      cyc_be_q   <= '0;
    end else begin
      cyc_op_q   <= nxt_op;
      cyc_addr_q <= nxt_addr;
      cyc_be_q   <= byte_en_i;
    end
  end

  assign rd_now = (cyc_op_q == OP_READ);

  zt_write_queue #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pipe_i    (pipe_mode_i),
    .in_wr_i   (cyc_op_q == OP_WRITE),
    .in_addr_i (cyc_addr_q),
    .in_be_i   (cyc_be_q),
    .cm_en_o   (cm_en),
    .cm_addr_o (cm_addr),
    .cm_be_o   (cm_be)
  );

  zt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (cm_en),
    .waddr_i (cm_addr),
    .wbe_i   (cm_be),
    .wdata_i (dq_i),
    .raddr_i (cyc_addr_q),
    .rdata_o (arr_rd)
  );

  assign fwd_hit = cm_en && (cm_addr == cyc_addr_q);

  zt_read_port #(.LANES(LANES), .BYTE_W(BYTE_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pipe_i    (pipe_mode_i),
    .oe_i      (oe_i),
    .sleep_i   (sleep_i),
    .rd_now_i  (rd_now),
    .arr_i     (arr_rd),
    .fwd_hit_i (fwd_hit),
    .fwd_be_i  (cm_be),
    .wdata_i   (dq_i),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o)
  );

  AST_NO_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !cm_en); // R6
  AST_SLEEP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (cyc_op_q == OP_IDLE)); // R10

endmodule

// File: tb/zt_sram_bench.sv
module zt_sram_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NL = 2;
  localparam int BW = 9;
  localparam int DW = NL * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pipe = 1'b1;
  logic          ilv = 1'b0;
  logic          s0 = 1'b0, s1 = 1'b0, s2 = 1'b0;
  logic          adv = 1'b0, wr = 1'b0;
  logic [NL-1:0] be = '0;
  logic [AW-1:0] addr = '0;
  logic          oe = 1'b1, slp = 1'b0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  zt_sram u_zt_sram (
    .clk_i(clk), .rst_ni(rst_n), .pipe_mode_i(pipe), .burst_ilv_i(ilv),
    .sel0_i(s0), .sel1_i(s1), .sel2_i(s2), .adv_i(adv), .wr_i(wr),
    .byte_en_i(be), .addr_i(addr), .oe_i(oe), .sleep_i(slp),
    .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  // Behavioural reference model.
  typedef struct { int due; int ad; logic [NL-1:0] en; } pw_t;
  typedef struct { int due; int ad; } pr_t;
  pw_t pw_q[$];
  pr_t pr_q[$];
  logic [DW-1:0] mm [int];
  logic [NL-1:0] mk [int];
  int   edge_n = 0;
  bit   m_live = 0, m_wr = 0;
  int   m_base = 0, m_cnt = 0;
  bit   exp_v = 0, exp_k = 0;
  logic [DW-1:0] exp_d = '0;
  logic [31:0] lcg = 32'h1234_5678;
  bit   g_oe = 1, g_slp = 0;
  int   n_chk = 0, n_err = 0;
  string tag = "R11";

  task automatic check_outputs();
    logic exp_oe;
    exp_oe = exp_v && oe && !slp;
    n_chk++;
    if (dq_oe !== exp_oe) begin
      n_err++;
      $display("FAIL %s edge %0d dq_oe_o actual %0b expected %0b", tag, edge_n, dq_oe, exp_oe);
    end
    if (exp_v && exp_k) begin
      n_chk++;
      if (dq_out !== exp_d) begin
        n_err++;
        $display("FAIL %s edge %0d dq_o actual %h expected %h", tag, edge_n, dq_out, exp_d);
      end
    end
  endtask

  task automatic cyc(input logic [2:0] cs, input bit a_adv, input bit a_wr,
                     input int a, input logic [NL-1:0] a_be);
    bit act, isw;
    int ea;
    logic [DW-1:0] w;
    @(negedge clk);
    {s2, s1, s0} = cs;
    adv = a_adv; wr = a_wr; addr = a[AW-1:0]; be = a_be;
    oe = g_oe; slp = g_slp;
    dq_in = 18'h25A5A;
    foreach (pw_q[i]) begin
      if (pw_q[i].due == edge_n + 1) begin
        lcg = lcg * 32'd1103515245 + 32'd12345;
        dq_in = lcg[29:12];
      end
    end
    @(posedge clk);
    edge_n++;
    act = 0; isw = 0; ea = 0;
    if (!g_slp) begin
      if (a_adv) begin
        if (m_live) begin
          act = 1; isw = m_wr; m_cnt = (m_cnt + 1) % 4;
          ea = (m_base & ~3) | (ilv ? ((m_base & 3) ^ m_cnt) : (((m_base & 3) + m_cnt) % 4));
        end
      end else if (cs == 3'b111) begin
        act = 1; isw = a_wr; m_base = a % 256; m_cnt = 0; m_wr = a_wr; ea = a % 256;
      end
    end
    m_live = act;
    for (int i = pw_q.size() - 1; i >= 0; i--) begin
      if (pw_q[i].due == edge_n) begin
        if (!mm.exists(pw_q[i].ad)) begin mm[pw_q[i].ad] = '0; mk[pw_q[i].ad] = '0; end
        w = mm[pw_q[i].ad];
        for (int l = 0; l < NL; l++) begin
          if (pw_q[i].en[l]) begin
            w[l*BW +: BW] = dq_in[l*BW +: BW];
            mk[pw_q[i].ad][l] = 1'b1;
          end
        end
        mm[pw_q[i].ad] = w;
        pw_q.delete(i);
      end
    end
    if (act && isw) pw_q.push_back('{edge_n + (pipe ? 2 : 1), ea, a_be});
    if (act && !isw) pr_q.push_back('{edge_n + (pipe ? 1 : 0), ea});
    exp_v = 0;
    for (int i = pr_q.size() - 1; i >= 0; i--) begin
      if (pr_q[i].due == edge_n) begin
        exp_v = 1;
        exp_k = mm.exists(pr_q[i].ad) && (&mk[pr_q[i].ad]);
        exp_d = mm.exists(pr_q[i].ad) ? mm[pr_q[i].ad] : '0;
        pr_q.delete(i);
      end
    end
    #(CLK_PERIOD/4);
    check_outputs();
  endtask

  task automatic wr1(input int a, input logic [NL-1:0] e); cyc(3'b111, 0, 1, a, e); endtask
  task automatic rd1(input int a); cyc(3'b111, 0, 0, a, '0); endtask
  task automatic nxt(); cyc(3'b000, 1, 0, 0, 2'b11); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(3'b000, 0, 0, 0, '0); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; {s2, s1, s0} = 3'b000; adv = 0; wr = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    pw_q.delete(); pr_q.delete(); m_live = 0; exp_v = 0;
    #1;
    n_chk++;
    if (dq_oe !== 1'b0) begin
      n_err++;
      $display("FAIL R11 reset dq_oe_o actual %0b expected 0", dq_oe);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog R1 actual running expected finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tag = "R11"; do_reset();
    // Pipelined timing
    tag = "R1";  for (int i = 0; i < 8; i++) wr1(i, 2'b11);
    tag = "R2";  for (int i = 0; i < 8; i++) rd1(i);
    tag = "R4";  wr1(9, 2'b11); idle(1); wr1(10, 2'b11); rd1(9); rd1(10);
    tag = "R6";  for (int i = 0; i < 6; i++) begin wr1(16 + i, 2'b11); rd1(i); end
    idle(2);
    tag = "R8";  wr1(3, 2'b01); rd1(3); wr1(3, 2'b10); rd1(3); wr1(4, 2'b11); rd1(4);
                 wr1(5, 2'b10); idle(1); rd1(5);
    tag = "R5";  wr1(6, 2'b00); idle(2); rd1(6); wr1(7, 2'b01); idle(3); rd1(7);
    tag = "R7";  wr1(8'h21, 2'b11); for (int i = 0; i < 5; i++) nxt();
                 rd1(8'h21); for (int i = 0; i < 5; i++) nxt();
                 idle(2); ilv = 1'b1;
                 wr1(8'h46, 2'b11); nxt(); nxt(); nxt();
                 rd1(8'h46); nxt(); nxt(); nxt(); rd1(8'h45); nxt(); nxt();
                 idle(1); nxt(); nxt(); ilv = 1'b0;
    tag = "R12"; cyc(3'b110, 0, 0, 1, '0); cyc(3'b101, 0, 0, 2, '0); cyc(3'b011, 0, 1, 3, 2'b11);
                 rd1(1); cyc(3'b011, 0, 0, 0, '0); nxt(); rd1(2);
    tag = "R9";  g_oe = 0; rd1(0); rd1(1); rd1(2); g_oe = 1; rd1(3); idle(1);
    tag = "R10"; wr1(30, 2'b11); g_slp = 1; rd1(30); wr1(31, 2'b11); nxt(); idle(1);
                 g_slp = 0; nxt(); rd1(30); rd1(31); rd1(1); g_slp = 1; idle(1); g_slp = 0; idle(2);
    // Flow-through timing
    pipe = 1'b0;
    tag = "R3";  for (int i = 0; i < 4; i++) wr1(8'h80 + i, 2'b11);
                 for (int i = 0; i < 4; i++) rd1(8'h80 + i);
                 for (int i = 0; i < 4; i++) begin wr1(8'h90 + i, 2'b11); rd1(8'h90 + i); end
    tag = "R4";  wr1(8'h80, 2'b10); rd1(8'h80); rd1(0); wr1(8'h81, 2'b01); wr1(8'h82, 2'b11); rd1(8'h81);
    tag = "R7";  ilv = 1'b1; wr1(8'hA3, 2'b11); nxt(); nxt(); nxt();
                 rd1(8'hA3); nxt(); nxt(); nxt(); nxt(); ilv = 1'b0;
                 rd1(8'hA2); nxt(); nxt(); nxt();
    tag = "R9";  g_oe = 0; rd1(8'h80); g_oe = 1; rd1(8'h81);
    tag = "R10"; g_slp = 1; rd1(8'h80); g_slp = 0; rd1(8'h82); idle(2);
    tag = "R11"; do_reset(); rd1(8'h80); rd1(8'h90); idle(1);
    pipe = 1'b1; idle(1); rd1(8'h21); rd1(3); idle(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule